// File: doc/BRIEF.md
# Memory Protection Region Checker

This block guards a memory port. Software programs up to eight regions through a small write-only configuration port: it first selects a region index, then writes that region's base address and its attribute word (size, permission, enable). Every access presented on the access port is compared against all enabled regions in parallel. The block then emits a registered verdict one cycle later: either a pass pulse or a fault pulse together with a held copy of the faulting address.

Region sizes are powers of two. A base address that is not a multiple of the programmed size is accepted without complaint. The region then shrinks to the largest power of two that the base is aligned to. For example, base 0x2001_FD80 with a 0x100-byte size covers only 0x2001_FD80 to 0x2001_FDFF. When several regions match, the highest-numbered one decides the permission. A global enable turns checking off entirely. Privilege and read/write arrive as plain inputs.

Top module: `mpu_region_guard`

## Requirements
- R1: After reset, faultPulse and accOk are low, faultAddr is zero, every region is disabled and global checking is off.
- R2: While global checking is off (control word bit 0 clear), every valid access yields accOk and no fault, whatever the region state.
- R3: A configuration write uses cfgSel: 0 selects the region (index taken from data bits [2:0]), 1 writes that region's base, 2 writes its attribute word and 3 writes the global control word. Base and attribute writes go to the region currently selected.
- R4: Attribute bit 0 enables the region. Bits [5:1] hold a field f giving a size of 2^(f+1) bytes. A disabled region, or one with f below 4, never matches.
- R5: A region whose base is a multiple of its size covers exactly base up to base+size-1.
- R6: When the base is not a multiple of the size, the covered range is the base plus the largest power of two dividing the base, capped at the programmed size. No error indication of any kind is produced.
- R7: With global checking on, an access that matches no enabled region faults.
- R8: When several enabled regions match, the highest-numbered one supplies the permission.
- R9: Attribute bits [9:8] hold the permission: 0 faults every access, 1 allows only privileged accesses, 2 allows reads only, 3 allows everything.
- R10: A valid access produces exactly one of faultPulse or accOk, one cycle later, for one cycle. faultAddr takes the address of each fault and holds it until the next fault.
- R11: A configuration write takes effect at the clock edge that accepts it. An access in the same cycle is judged with the previous configuration.
- R12: Base address bits [4:0] are ignored and stored as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Configuration write strobe |
| cfgSel | input | 2 | Configuration target: 0 select, 1 base, 2 attribute, 3 global control |
| cfgWrData | input | 32 | Configuration write data |
| accValid | input | 1 | Access present this cycle |
| accAddr | input | 32 | Access byte address |
| accWrite | input | 1 | 1 for write, 0 for read |
| accPriv | input | 1 | 1 for a privileged access |
| faultPulse | output | 1 | One-cycle fault verdict |
| accOk | output | 1 | One-cycle pass verdict |
| faultAddr | output | 32 | Address of the most recent fault |

## Verification
An access driven in cycle t has its verdict registered at the edge closing t. The bench therefore drives on a falling edge and reads faultPulse, accOk and faultAddr at the next falling edge, after exactly one rising edge. Configuration writes are also driven on a falling edge, so the next access already sees them. One directed case puts a write and an access in the same cycle to show that the access is judged with the old settings. A table of accesses then covers aligned, shrunk, overlapping, disabled and permission cases, each with its expected verdict.

// File: rtl/mpu_guard_pkg.sv
package mpu_guard_pkg;

  // configuration port targets
  localparam logic [1:0] SEL_REGION = 2'd0;
  localparam logic [1:0] SEL_BASE   = 2'd1;
  localparam logic [1:0] SEL_ATTR   = 2'd2;
  localparam logic [1:0] SEL_GLOBAL = 2'd3;

  // attribute word layout
  localparam int EN_BIT    = 0;
  localparam int SIZE_LSB  = 1;
  localparam int SIZE_W    = 5;
  localparam int PERM_LSB  = 8;
  localparam int MIN_FIELD = 4;              // smallest legal size field
  localparam int MIN_LOG2  = MIN_FIELD + 1;  // 32-byte granule

  typedef enum logic [1:0] {
    PERM_NONE = 2'd0,
    PERM_PRIV = 2'd1,
    PERM_RO   = 2'd2,
    PERM_FULL = 2'd3
  } perm_e;

  // control -> datapath strobes
  typedef struct packed {
    logic selWr;
    logic baseWr;
    logic attrWr;
    logic globWr;
    logic faultNow;
    logic passNow;
  } ctlStrobe_t;

  // datapath -> control lookup result
  typedef struct packed {
    logic  globalEn;
    logic  hitAny;
    perm_e hitPerm;
  } dpStatus_t;

endpackage

// File: rtl/mpu_guard_dp.sv
module mpu_guard_dp
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  output dpStatus_t         status,
  output logic              faultPulse,
  output logic              accOk,
  output logic [ADDR_W-1:0] faultAddr
);

  localparam int IDX_W = (NUM_REGIONS > 1) ? $clog2(NUM_REGIONS) : 1;
  localparam int LOG_W = $clog2(ADDR_W + 1);
  localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << MIN_LOG2) - ADDR_W'(1);

  logic [IDX_W-1:0]       selIdx;
  logic                   globalEn;
  logic [NUM_REGIONS-1:0] hit;
  perm_e                  regPerm [NUM_REGIONS];
  logic                   hitAny;
  perm_e                  hitPerm;

  // number of zero bits below the lowest set bit; ADDR_W for zero
  function automatic logic [LOG_W-1:0] trailZeros(input logic [ADDR_W-1:0] v);
    logic [LOG_W-1:0] r;
    r = LOG_W'(ADDR_W);
    for (int b = ADDR_W - 1; b >= 0; b--) begin
      if (v[b]) r = LOG_W'(b);
    end
    return r;
  endfunction

  // ones at and above bit position lg
  function automatic logic [ADDR_W-1:0] maskAbove(input logic [LOG_W-1:0] lg);
    logic [ADDR_W-1:0] m;
    for (int b = 0; b < ADDR_W; b++) begin
      m[b] = (LOG_W'(b) >= lg);
    end
    return m;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selIdx   <= '0;
      globalEn <= 1'b0;
    end else begin
      if (strobe.selWr) selIdx   <= cfgWrData[IDX_W-1:0];
      if (strobe.globWr) globalEn <= cfgWrData[0];
    end
  end

  for (genvar i = 0; i < NUM_REGIONS; i++) begin : g_region
    logic [ADDR_W-1:0] baseQ;
    logic [SIZE_W-1:0] sizeQ;
    perm_e             permQ;
    logic              enQ;
    logic              wrHere;
    logic [LOG_W-1:0]  cfgLog2;
    logic [LOG_W-1:0]  alignLog2;
    logic [LOG_W-1:0]  effLog2;
    logic [ADDR_W-1:0] keepMask;

    assign wrHere = (selIdx == IDX_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        baseQ <= '0;
        sizeQ <= '0;
        permQ <= PERM_NONE;
        enQ   <= 1'b0;
      end else begin
        if (strobe.baseWr && wrHere) baseQ <= cfgWrData & ~LOW_MASK;
        if (strobe.attrWr && wrHere) begin
          sizeQ <= cfgWrData[SIZE_LSB +: SIZE_W];
          permQ <= perm_e'(cfgWrData[PERM_LSB +: 2]);
          enQ   <= cfgWrData[EN_BIT];
        end
      end
    end

    // effective size is the smaller of programmed size and base alignment
    always_comb begin
      cfgLog2   = LOG_W'(sizeQ) + LOG_W'(1);
      alignLog2 = trailZeros(baseQ);
      effLog2   = (alignLog2 < cfgLog2) ? alignLog2 : cfgLog2;
      keepMask  = maskAbove(effLog2);
    end

    assign hit[i] = enQ && (sizeQ >= SIZE_W'(MIN_FIELD)) &&
                    ((accAddr & keepMask) == (baseQ & keepMask));
    assign regPerm[i] = permQ;
  end

  // later regions override earlier ones
  always_comb begin
    hitAny  = 1'b0;
    hitPerm = PERM_NONE;
    for (int i = 0; i < NUM_REGIONS; i++) begin
      if (hit[i]) begin
        hitAny  = 1'b1;
        hitPerm = regPerm[i];
      end
    end
  end

  assign status = '{globalEn: globalEn, hitAny: hitAny, hitPerm: hitPerm};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      faultPulse <= 1'b0;
      accOk      <= 1'b0;
      faultAddr  <= '0;
    end else begin
      faultPulse <= strobe.faultNow;
      accOk      <= strobe.passNow;
      if (strobe.faultNow) faultAddr <= accAddr;
    end
  end

  assert_verdict_excl_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({faultPulse, accOk}));

  assert_verdict_needs_access_R10: assert property (@(posedge clk) disable iff (!rstN)
    (faultPulse || accOk) |-> $past(accValid));

  assert_fault_addr_capture_R10: assert property (@(posedge clk) disable iff (!rstN)
    faultPulse |-> (faultAddr == $past(accAddr)));

  assert_fault_addr_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !faultPulse |-> $stable(faultAddr));

  assert_global_off_pass_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && !globalEn) |=> (accOk && !faultPulse));

  assert_no_hit_fault_R7: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && globalEn && !hitAny) |=> faultPulse);

endmodule

// File: rtl/mpu_guard_ctrl.sv
module mpu_guard_ctrl
  import mpu_guard_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgWrEn,
  input  logic [1:0] cfgSel,
  input  logic       accValid,
  input  logic       accWrite,
  input  logic       accPriv,
  input  dpStatus_t  status,
  output ctlStrobe_t strobe
);

  logic permOk;
  logic allowed;

  always_comb begin
    unique case (status.hitPerm)
      PERM_NONE: permOk = 1'b0;
      PERM_PRIV: permOk = accPriv;
      PERM_RO:   permOk = !accWrite;
      PERM_FULL: permOk = 1'b1;
      default:   permOk = 1'b0;
    endcase
  end

  assign allowed = !status.globalEn || (status.hitAny && permOk);

  always_comb begin
    strobe.selWr    = cfgWrEn && (cfgSel == SEL_REGION);
    strobe.baseWr   = cfgWrEn && (cfgSel == SEL_BASE);
    strobe.attrWr   = cfgWrEn && (cfgSel == SEL_ATTR);
    strobe.globWr   = cfgWrEn && (cfgSel == SEL_GLOBAL);
    strobe.faultNow = accValid && !allowed;
    strobe.passNow  = accValid && allowed;
  end

  assert_cfg_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.selWr, strobe.baseWr, strobe.attrWr, strobe.globWr}));

  assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && status.globalEn && status.hitAny &&
     status.hitPerm == PERM_RO && accWrite) |-> strobe.faultNow);

  assert_priv_only_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && status.globalEn && status.hitAny &&
     status.hitPerm == PERM_PRIV && !accPriv) |-> strobe.faultNow);

  assert_full_pass_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && status.globalEn && status.hitAny &&
     status.hitPerm == PERM_FULL) |-> strobe.passNow);

endmodule

// File: rtl/mpu_region_guard.sv
module mpu_region_guard
  import mpu_guard_pkg::*;
#(
  parameter int NUM_REGIONS = 8,
  parameter int ADDR_W      = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrEn,
  input  logic [1:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgWrData,
  input  logic              accValid,
  input  logic [ADDR_W-1:0] accAddr,
  input  logic              accWrite,
  input  logic              accPriv,
  output logic              faultPulse,
  output logic              accOk,
  output logic [ADDR_W-1:0] faultAddr
);

  ctlStrobe_t strobe;
  dpStatus_t  status;

  mpu_guard_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cfgWrEn  (cfgWrEn),
    .cfgSel   (cfgSel),
    .accValid (accValid),
    .accWrite (accWrite),
    .accPriv  (accPriv),
    .status   (status),
    .strobe   (strobe)
  );

  mpu_guard_dp #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .cfgWrData  (cfgWrData),
    .accValid   (accValid),
    .accAddr    (accAddr),
    .status     (status),
    .faultPulse (faultPulse),
    .accOk      (accOk),
    .faultAddr  (faultAddr)
  );

endmodule

// File: tb/mpu_region_guard_tb.sv
module mpu_region_guard_tb;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 19;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [1:0]  cfgSel = '0;
  logic [31:0] cfgWrData = '0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0;
  logic        accWrite = 1'b0;
  logic        accPriv = 1'b0;
  logic        faultPulse;
  logic        accOk;
  logic [31:0] faultAddr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mpu_region_guard u_dut (
    .clk        (clk),
    .rstN       (rstN),
    .cfgWrEn    (cfgWrEn),
    .cfgSel     (cfgSel),
    .cfgWrData  (cfgWrData),
    .accValid   (accValid),
    .accAddr    (accAddr),
    .accWrite   (accWrite),
    .accPriv    (accPriv),
    .faultPulse (faultPulse),
    .accOk      (accOk),
    .faultAddr  (faultAddr)
  );

  // {addr, write, priv, expectFault, requirement number}
  // regions: r0 0x1000_0000/64K full, r5 0x1000_4000/1K priv-only (over r0),
  // r3 0x2001_FD80/0x100 read-only (shrinks to 0x80), r6 0x4000_0000 none,
  // r7 size field 3 (never matches), r2 disabled, r1 0x7000_0100/8K full (shrinks to 0x100)
  localparam logic [38:0] VEC [NUM_VEC] = '{
    {32'h1000_0000, 1'b1, 1'b0, 1'b0, 4'd5},   // R5 aligned start
    {32'h1000_FFFC, 1'b0, 1'b0, 1'b0, 4'd5},   // R5 aligned end
    {32'h1001_0000, 1'b0, 1'b1, 1'b1, 4'd7},   // R7 past r0
    {32'h1000_4000, 1'b0, 1'b0, 1'b1, 4'd8},   // R8 r5 wins over r0
    {32'h1000_4000, 1'b1, 1'b1, 1'b0, 4'd9},   // R9 privileged ok
    {32'h1000_43FC, 1'b0, 1'b0, 1'b1, 4'd8},   // R8 top of r5
    {32'h1000_4400, 1'b0, 1'b0, 1'b0, 4'd8},   // R8 back to r0
    {32'h2001_FD80, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 shrunk start
    {32'h2001_FDFC, 1'b0, 1'b0, 1'b0, 4'd6},   // R6 shrunk end
    {32'h2001_FE00, 1'b0, 1'b1, 1'b1, 4'd6},   // R6 past shrunk end
    {32'h2001_FD80, 1'b1, 1'b1, 1'b1, 4'd9},   // R9 write to read-only
    {32'h2001_FD7C, 1'b0, 1'b1, 1'b1, 4'd6},   // R6 below base
    {32'h4000_0010, 1'b0, 1'b1, 1'b1, 4'd9},   // R9 no-access region
    {32'h5000_0000, 1'b0, 1'b1, 1'b1, 4'd4},   // R4 size field too small
    {32'h6000_0000, 1'b0, 1'b1, 1'b1, 4'd4},   // R4 disabled region
    {32'h7000_0100, 1'b1, 1'b0, 1'b0, 4'd6},   // R6 second shrink case
    {32'h7000_01FC, 1'b0, 1'b0, 1'b0, 4'd12},  // R12 low base bits dropped
    {32'h7000_0200, 1'b0, 1'b1, 1'b1, 4'd6},   // R6 past 0x100 window
    {32'h7000_0000, 1'b0, 1'b1, 1'b1, 4'd6}    // R6 below base
  };

  function automatic logic [31:0] mkAttr(input logic [1:0] perm, input logic [4:0] field,
                                         input logic en);
    return (32'(perm) << 8) | (32'(field) << 1) | 32'(en);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfgWrite(input logic [1:0] sel, input logic [31:0] data);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgSel    = sel;
    cfgWrData = data;
    @(negedge clk);
    cfgWrEn   = 1'b0;
  endtask

  task automatic regionSet(input int idx, input logic [31:0] base, input logic [31:0] attr);
    cfgWrite(2'd0, 32'(idx));
    cfgWrite(2'd1, base);
    cfgWrite(2'd2, attr);
  endtask

  // drive one access, read the verdict one rising edge later
  task automatic doAccess(input logic [31:0] addr, input logic wr, input logic pr,
                          input logic expFault, input string tag);
    @(negedge clk);
    accValid = 1'b1;
    accAddr  = addr;
    accWrite = wr;
    accPriv  = pr;
    @(negedge clk);
    accValid = 1'b0;
    check(faultPulse == expFault, {tag, " faultPulse"}, 32'(faultPulse), 32'(expFault));
    check(accOk == !expFault, {tag, " accOk"}, 32'(accOk), 32'(!expFault));
    if (expFault) check(faultAddr == addr, {tag, " faultAddr"}, faultAddr, addr);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: actual=%h expected=%h", 32'd0, 32'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(faultPulse == 1'b0, "R1 faultPulse", 32'(faultPulse), 32'd0);
    check(accOk == 1'b0, "R1 accOk", 32'(accOk), 32'd0);
    check(faultAddr == 32'd0, "R1 faultAddr", faultAddr, 32'd0);
    // R1 / R2: checking off after reset, everything passes
    doAccess(32'h1234_5678, 1'b1, 1'b0, 1'b0, "R2 after reset");

    regionSet(0, 32'h1000_0000, mkAttr(2'd3, 5'd15, 1'b1));
    regionSet(5, 32'h1000_4000, mkAttr(2'd1, 5'd9, 1'b1));
    regionSet(3, 32'h2001_FD80, mkAttr(2'd2, 5'd7, 1'b1));
    regionSet(6, 32'h4000_0000, mkAttr(2'd0, 5'd11, 1'b1));
    regionSet(7, 32'h5000_0000, mkAttr(2'd3, 5'd3, 1'b1));
    regionSet(2, 32'h6000_0000, mkAttr(2'd3, 5'd10, 1'b0));
    regionSet(1, 32'h7000_010F, mkAttr(2'd3, 5'd12, 1'b1));  // R12 low bits set

    // R2 still off: no-access region passes
    doAccess(32'h4000_0000, 1'b0, 1'b0, 1'b0, "R2 regions programmed, global off");

    cfgWrite(2'd3, 32'd1);

    for (int v = 0; v < NUM_VEC; v++) begin
      doAccess(VEC[v][38:7], VEC[v][6], VEC[v][5], VEC[v][4],
               $sformatf("R%0d vec%0d", VEC[v][3:0], v));
    end

    // R10 fault address holds through a passing access (last vector faulted)
    doAccess(32'h1000_0010, 1'b0, 1'b0, 1'b0, "R10 pass after fault");
    check(faultAddr == 32'h7000_0000, "R10 faultAddr held", faultAddr, 32'h7000_0000);

    // R3 select uses data bits [2:0]: 9 selects region 1, then disable it
    cfgWrite(2'd0, 32'h0000_0009);
    cfgWrite(2'd2, mkAttr(2'd3, 5'd12, 1'b0));
    doAccess(32'h7000_0100, 1'b0, 1'b1, 1'b1, "R3 region1 disabled via select 9");

    // R11 write and access in the same cycle: old config applies
    cfgWrite(2'd0, 32'd0);
    @(negedge clk);
    cfgWrEn   = 1'b1;
    cfgSel    = 2'd2;
    cfgWrData = mkAttr(2'd3, 5'd15, 1'b0);
    accValid  = 1'b1;
    accAddr   = 32'h1000_0100;
    accWrite  = 1'b0;
    accPriv   = 1'b0;
    @(negedge clk);
    cfgWrEn  = 1'b0;
    accValid = 1'b0;
    check(accOk == 1'b1, "R11 same-cycle accOk", 32'(accOk), 32'd1);
    check(faultPulse == 1'b0, "R11 same-cycle faultPulse", 32'(faultPulse), 32'd0);
    doAccess(32'h1000_0100, 1'b0, 1'b0, 1'b1, "R11 next access sees disable");

    // R2 global off again
    cfgWrite(2'd3, 32'd0);
    doAccess(32'h1000_0100, 1'b0, 1'b0, 1'b0, "R2 global off again");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule